// File: doc/BRIEF.md
# Dual-Phase Clock Generator

This block derives two clocks of equal frequency from a fast reference clock. The output period is a programmable whole number of reference ticks. The second output, the auxiliary clock, is displaced from the primary clock by a programmable number of reference ticks. A direction bit chooses whether the auxiliary clock trails or precedes the primary one.

All settings come from a single 32-bit command word. A word is accepted only when both of its identity nibbles carry the block's own identity. Foreign words are dropped and recorded in a sticky error flag.

A new setting is held back until the primary clock is about to begin a fresh period, so a reprogramming never chops a pulse short. Status outputs report the setting that is currently in force.

Top module: `dual_phase_clkgen`

## Requirements
- R1: Command word fields: bits [31:28] and [27:24] are identity nibbles, and both must equal 0x2 for the word to be accepted. Bits [23:13] are ignored. Bit 12 is a halt bit, bit 11 is a lead bit, bits [10:6] are the delay D and bits [5:0] are the divisor N.
- R2: A word whose identity nibbles do not both equal 0x2 changes neither the outputs nor the status. It sets `idErr`, which stays set until reset.
- R3: While running, `clkMain` has a period of N reference cycles and is high for floor(N/2) consecutive cycles of each period.
- R4: With the lead bit at 0, `clkAux` is `clkMain` delayed by D reference cycles.
- R5: With the lead bit at 1, `clkAux` is `clkMain` advanced by D reference cycles.
- R6: A delay D ≥ N acts as D mod N, and the status reports the reduced value.
- R7: With the halt bit set, both clocks stay low and `statusActive` is 0.
- R8: A divisor of 0 or 1 keeps both clocks low and `statusActive` at 0.
- R9: A word accepted while running takes effect only where the primary clock starts a new period. No high or low phase of `clkMain` is ever shortened.
- R10: From the idle state, `clkMain` rises after the second reference edge that follows the edge capturing the write.
- R11: `statusDiv`, `statusDly` and `statusActive` report the divisor, reduced delay and running state currently in force.
- R12: After reset both clocks are low, all status outputs are zero and `idErr` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | One-cycle strobe marking a valid `cfgWord` |
| cfgWord | input | 32 | Command word |
| clkMain | output | 1 | Primary divided clock |
| clkAux | output | 1 | Auxiliary divided clock, phase shifted |
| statusDiv | output | 6 | Divisor in force |
| statusDly | output | 5 | Reduced delay in force |
| statusActive | output | 1 | Outputs are toggling |
| idErr | output | 1 | Sticky flag for rejected words |

## Verification
The bench targets several corner cases:
- Odd divisors: getting the halving wrong gives a duty of ceil(N/2) instead of floor(N/2).
- Delays at or above the divisor: a design that skips the modulo would index past the period and produce a wrong or missing auxiliary pulse.
- The smallest legal divisor of 2.
- Lead versus lag: swapping them mirrors the auxiliary waveform.

A reprogramming in the middle of a period is watched pulse by pulse. A design that loads at once would emit a high or low phase of odd length.

Rejected identities, the halt bit and divisors 0 and 1 are checked to leave the outputs and status frozen or low. A design that treats one identity nibble as don't-care would switch to the foreign setting.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int DIV_W = 6;
  localparam int DLY_W = 5;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [DLY_W-1:0] dly;
    logic             lead;
    logic             halt;
  } cfg_t;

  typedef struct packed {
    logic load;
    cfg_t cfg;
  } ctrl2dp_t;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter logic [3:0] OWN_ID = 4'h2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrite,
  input  logic [31:0] cfgWord,
  input  logic        running,
  input  logic        atWrap,
  output ctrl2dp_t    toDp,
  output logic        idErr
);
  logic             idOk;
  logic [DIV_W-1:0] rawDiv;
  logic [DLY_W-1:0] rawDly;
  logic [DLY_W-1:0] redDly;
  logic             unusedResv;
  cfg_t             decoded;
  cfg_t             pendCfg;
  logic             pendValid;
  logic             loadNow;

  assign idOk       = (cfgWord[31:28] == OWN_ID) && (cfgWord[27:24] == OWN_ID);
  assign unusedResv = ^cfgWord[23:13];
  assign rawDiv     = cfgWord[DIV_W-1:0];
  assign rawDly     = cfgWord[DIV_W+DLY_W-1:DIV_W];

  always_comb begin
    if (rawDiv < DIV_W'(2)) redDly = '0;
    else redDly = DLY_W'(DIV_W'(rawDly) % rawDiv);
    decoded.div  = rawDiv;
    decoded.dly  = redDly;
    decoded.lead = cfgWord[11];
    decoded.halt = cfgWord[12];
  end

  assign loadNow   = pendValid && (!running || atWrap);
  assign toDp.load = loadNow;
  assign toDp.cfg  = pendCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg   <= '0;
      pendValid <= 1'b0;
      idErr     <= 1'b0;
    end else begin
      if (cfgWrite && idOk) begin
        pendCfg   <= decoded;
        pendValid <= 1'b1;
      end else if (loadNow) begin
        pendValid <= 1'b0;
      end
      if (cfgWrite && !idOk) idErr <= 1'b1;
    end
  end

  // R2
  id_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    idErr |=> idErr);
  // R1
  foreign_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !idOk) |=> $stable(pendCfg));
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl2dp_t         toDp,
  output logic             clkMain,
  output logic             clkAux,
  output logic             running,
  output logic             atWrap,
  output logic [DIV_W-1:0] statusDiv,
  output logic [DLY_W-1:0] statusDly,
  output logic             statusActive
);
  localparam int XW = DIV_W + 1;

  cfg_t             actCfg;
  logic [DIV_W-1:0] phase;
  logic [XW-1:0]    divX, halfX, phaseX, dlyX, sumX, auxPh;

  assign running = !actCfg.halt && (actCfg.div >= DIV_W'(2));
  assign atWrap  = running && (phase == actCfg.div - DIV_W'(1));

  assign divX   = XW'(actCfg.div);
  assign halfX  = XW'(actCfg.div >> 1);
  assign phaseX = XW'(phase);
  assign dlyX   = XW'(actCfg.dly);

  always_comb begin
    if (actCfg.lead) sumX = phaseX + dlyX;
    else sumX = phaseX + divX - dlyX;
    auxPh = (sumX >= divX) ? sumX - divX : sumX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg  <= '0;
      phase   <= '0;
      clkMain <= 1'b0;
      clkAux  <= 1'b0;
    end else begin
      if (toDp.load) begin
        actCfg <= toDp.cfg;
        phase  <= '0;
      end else if (!running || atWrap) begin
        phase <= '0;
      end else begin
        phase <= phase + DIV_W'(1);
      end
      clkMain <= running && (phaseX < halfX);
      clkAux  <= running && (auxPh < halfX);
    end
  end

  assign statusDiv    = actCfg.div;
  assign statusDly    = actCfg.dly;
  assign statusActive = running;

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (phase < actCfg.div));
  // R6
  dly_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (actCfg.dly < DLY_W'(actCfg.div) || actCfg.div > DIV_W'(31)));
  // R9
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !atWrap) |=> $stable(actCfg));
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (!clkMain && !clkAux));
endmodule

// File: rtl/dual_phase_clkgen.sv
module dual_phase_clkgen
  import dpc_pkg::*;
#(
  parameter logic [3:0] OWN_ID = 4'h2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [31:0]      cfgWord,
  output logic             clkMain,
  output logic             clkAux,
  output logic [DIV_W-1:0] statusDiv,
  output logic [DLY_W-1:0] statusDly,
  output logic             statusActive,
  output logic             idErr
);
  ctrl2dp_t toDp;
  logic     running;
  logic     atWrap;

  dpc_ctrl #(.OWN_ID(OWN_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .running(running), .atWrap(atWrap), .toDp(toDp), .idErr(idErr)
  );

  dpc_datapath u_dp (
    .clk(clk), .rstN(rstN), .toDp(toDp), .clkMain(clkMain), .clkAux(clkAux),
    .running(running), .atWrap(atWrap), .statusDiv(statusDiv),
    .statusDly(statusDly), .statusActive(statusActive)
  );
endmodule

// File: tb/dual_phase_clkgen_tb.sv
module dual_phase_clkgen_tb;
  localparam int CLK_P = 10;
  localparam int VEC_N = 7;
  // {lead, dly, div}
  localparam logic [11:0] VEC [VEC_N] = '{
    {1'b0, 5'd4, 6'd10}, {1'b1, 5'd4, 6'd10}, {1'b0, 5'd7, 6'd40},
    {1'b1, 5'd3, 6'd7},  {1'b0, 5'd12, 6'd8}, {1'b0, 5'd0, 6'd5},
    {1'b1, 5'd1, 6'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        clkMain, clkAux, statusActive, idErr;
  logic [5:0]  statusDiv;
  logic [4:0]  statusDly;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_phase_clkgen u_dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .clkMain(clkMain), .clkAux(clkAux), .statusDiv(statusDiv),
    .statusDly(statusDly), .statusActive(statusActive), .idErr(idErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [3:0] idHi, input logic [3:0] idLo, input logic halt,
                          input logic lead, input logic [4:0] dly, input logic [5:0] div);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgWord  = {idHi, idLo, 11'h5A5, halt, lead, dly, div};
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic checkPattern(input int n, input int d, input bit lead, input string req);
    int misMain = 0;
    int misAux = 0;
    int guard = 0;
    logic prev = clkMain;
    @(negedge clk);
    while (!(clkMain && !prev) && guard < 300) begin
      prev = clkMain;
      @(negedge clk);
      guard++;
    end
    for (int k = 0; k < 2 * n; k++) begin
      int p = k % n;
      int ap = lead ? (p + d) % n : (p + n - d) % n;
      if (clkMain !== (p < n / 2)) misMain++;
      if (clkAux !== (ap < n / 2)) misAux++;
      @(negedge clk);
    end
    check(misMain == 0 && guard < 300, "R3", misMain, 0);
    check(misAux == 0, req, misAux, 0);
  endtask

  task automatic checkIdle(input string req);
    int highs = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (clkMain || clkAux) highs++;
    end
    check(highs == 0, req, highs, 0);
    check(statusActive == 1'b0, req, statusActive, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!clkMain && !clkAux, "R12", {clkMain, clkAux}, 0);
    check(statusDiv == 0 && statusDly == 0 && !statusActive, "R12", statusDiv, 0);
    check(idErr == 1'b0, "R12", idErr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R3/R4/R5/R6/R11
    for (int i = 0; i < VEC_N; i++) begin
      int n = int'(VEC[i][5:0]);
      int d = int'(VEC[i][10:6]);
      bit ld = VEC[i][11];
      writeCfg(4'h2, 4'h2, 1'b0, ld, 5'(d), 6'(n));
      repeat (100) @(negedge clk);
      check(statusDiv == 6'(n) && statusActive, "R11", statusDiv, n);
      check(statusDly == 5'(d % n), (d >= n) ? "R6" : "R11", statusDly, d % n);
      checkPattern(n, d % n, ld, (d >= n) ? "R6" : (ld ? "R5" : "R4"));
    end
    check(idErr == 1'b0, "R2", idErr, 0);

    // R1 / R2: foreign identity nibbles ignored
    writeCfg(4'h2, 4'h2, 1'b0, 1'b0, 5'd4, 6'd10);
    repeat (60) @(negedge clk);
    writeCfg(4'h3, 4'h2, 1'b0, 1'b1, 5'd1, 6'd4);
    repeat (60) @(negedge clk);
    check(statusDiv == 6'd10 && statusDly == 5'd4, "R1", statusDiv, 10);
    check(idErr == 1'b1, "R2", idErr, 1);
    writeCfg(4'h2, 4'h6, 1'b0, 1'b1, 5'd1, 6'd4);
    repeat (60) @(negedge clk);
    check(statusDiv == 6'd10, "R1", statusDiv, 10);
    checkPattern(10, 4, 1'b0, "R2");
    check(idErr == 1'b1, "R2", idErr, 1);

    // R9: mid-period reprogramming from N=10 to N=4
    begin
      int runLen = 0;
      int badRuns = 0;
      int shortRuns = 0;
      bit first = 1'b1;
      logic cur;
      repeat (3) @(negedge clk);
      writeCfg(4'h2, 4'h2, 1'b0, 1'b0, 5'd1, 6'd4);
      cur = clkMain;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (clkMain == cur) runLen++;
        else begin
          if (!first && runLen + 1 != 5 && runLen + 1 != 2) badRuns++;
          if (!first && runLen + 1 == 2) shortRuns++;
          first = 1'b0;
          runLen = 0;
          cur = clkMain;
        end
      end
      check(badRuns == 0, "R9", badRuns, 0);
      check(shortRuns > 10, "R9", shortRuns, 11);
    end

    // R7 halt
    writeCfg(4'h2, 4'h2, 1'b1, 1'b0, 5'd2, 6'd10);
    repeat (40) @(negedge clk);
    checkIdle("R7");

    // R8 illegal divisors
    writeCfg(4'h2, 4'h2, 1'b0, 1'b0, 5'd0, 6'd1);
    repeat (5) @(negedge clk);
    checkIdle("R8");
    writeCfg(4'h2, 4'h2, 1'b0, 1'b0, 5'd0, 6'd0);
    repeat (5) @(negedge clk);
    checkIdle("R8");

    // R10 start-up latency from idle
    writeCfg(4'h2, 4'h2, 1'b0, 1'b0, 5'd2, 6'd6);
    @(negedge clk);
    check(clkMain == 1'b0, "R10", clkMain, 0);
    @(negedge clk);
    check(clkMain == 1'b1, "R10", clkMain, 1);
    checkPattern(6, 2, 1'b0, "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule